// File: doc/BRIEF.md
# Probabilistic Adjacent Row Refresher

This block sits next to the command scheduler of a DRAM memory controller and watches the stream of row open and row close events. Each event carries a bank and a row address. Every time a row is closed, the block runs one independent random trial. A trial succeeds with a small probability that software sets. When a trial succeeds, the block asks the scheduler to activate one row that physically neighbours the closed row, in the same bank. That extra activation restores the charge in a row that repeated hammering of its neighbour could otherwise disturb.

The block keeps no per-row history and no activation counters. Its only state is:
- a 32-bit pseudo-random generator that steps every cycle;
- the probability threshold;
- a single pending request, offered to the scheduler with a valid/ready handshake;
- a saturating count of requests that had to be dropped.

The probability is the threshold divided by 65536. A threshold of about 66 gives 0.001 and a threshold of about 328 gives 0.005. A threshold of zero turns the block off.

Top module: `para_refresher`

## Requirements
- R1: A synchronous reset, active high on `rst`, leaves the block in this state: `req_valid` low, `drop_count` zero, the threshold zero and the generator loaded with the seed 32'hC0FFEE11.
- R2: The generator is a right-shifting Galois LFSR that steps on every cycle outside reset. When bit 0 is 1 the next value is (state >> 1) XOR 32'h80200003; otherwise the next value is state >> 1.
- R3: A trial runs only in a cycle with `evt_valid` high and `evt_close` = 1, which is a row close. An open event (`evt_close` = 0) never produces a request.
- R4: A trial succeeds exactly when bits [15:0] of the generator value in that cycle are below the threshold. With the threshold at zero, no request is ever raised.
- R5: When `cfg_we` is high at a clock edge, the threshold is loaded from `cfg_threshold`. The new value governs trials from the next cycle onward.
- R6: A successful trial targets the bank of the closed row. When generator bit 31 is 1 it targets row+1, and when that bit is 0 it targets row-1.
- R7: At row 0 the target is always row 1. At the highest row index (all ones) the target is always that index minus 1.
- R8: The request appears on `req_valid`, `req_bank` and `req_row` in the cycle after the successful trial. It stays asserted and unchanged until it is accepted.
- R9: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A trial that succeeds in that same cycle loads the slot with its own request and is not dropped.
- R10: A trial that succeeds while the pending request is not being accepted is discarded. The discard raises `drop_count` by one; the count saturates at all ones.
- R11: Over a long run of closes with the scheduler always ready, the number of accepted requests stays within 20 % of closes × threshold / 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the threshold |
| cfg_threshold | input | 16 | New threshold; probability = value/65536 |
| evt_valid | input | 1 | A row event is present this cycle |
| evt_close | input | 1 | 1 = row close (precharge), 0 = row open |
| evt_bank | input | BANK_W | Bank of the event |
| evt_row | input | ROW_W | Row of the event |
| req_ready | input | 1 | Scheduler takes the pending request |
| req_valid | output | 1 | Neighbour refresh request pending |
| req_bank | output | BANK_W | Bank to refresh |
| req_row | output | ROW_W | Neighbour row to activate |
| drop_count | output | DROP_W | Saturating count of discarded successful trials |

## Verification
The assertions check the following on every cycle:
- a waiting request holds still until it is accepted;
- a request that is taken into a free slot lands in the closed row's bank, exactly one row away;
- the two edge rows turn inward;
- a zero threshold raises nothing;
- the drop counter steps by one and never falls;
- the generator never reaches the all-zero lock-up state.

Two behaviours can only be shown by the bench's cycle-exact reference model. One is that the generator sequence and the comparison against the threshold fire in exactly the right cycles. The other is the statistical firing rate over a long run of closes.

// File: rtl/para_refresher.sv
module para_refresher #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int DROP_W = 8,
  parameter logic [31:0] SEED = 32'hC0FFEE11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_threshold,
  input  logic              evt_valid,
  input  logic              evt_close,
  input  logic [BANK_W-1:0] evt_bank,
  input  logic [ROW_W-1:0]  evt_row,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [31:0]       TAPS     = 32'h80200003;
  localparam logic [ROW_W-1:0]  ROW_LAST = '1;
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [31:0]      lfsr;
  logic [15:0]      thr_q;
  logic             hit, go_up, slot_free;
  logic [ROW_W-1:0] target;

  assign hit       = evt_valid & evt_close & (lfsr[15:0] < thr_q);
  assign go_up     = (evt_row == '0) | ((evt_row != ROW_LAST) & lfsr[31]);
  assign target    = go_up ? evt_row + 1'b1 : evt_row - 1'b1;
  assign slot_free = ~req_valid | req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr       <= SEED;
      thr_q      <= '0;
      req_valid  <= 1'b0;
      req_bank   <= '0;
      req_row    <= '0;
      drop_count <= '0;
    end else begin
      lfsr <= lfsr[0] ? ((lfsr >> 1) ^ TAPS) : (lfsr >> 1);
      if (cfg_we) thr_q <= cfg_threshold;
      if (hit && slot_free) begin
        req_valid <= 1'b1;
        req_bank  <= evt_bank;
        req_row   <= target;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
      if (hit && !slot_free && drop_count != DROP_MAX)
        drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/para_refresher_checker.sv
module para_refresher_checker #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic              evt_close,
  input logic [BANK_W-1:0] evt_bank,
  input logic [ROW_W-1:0]  evt_row,
  input logic              req_ready,
  input logic              req_valid,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [DROP_W-1:0] drop_count,
  input logic [15:0]       thr_q,
  input logic              hit,
  input logic [31:0]       lfsr
);
  localparam logic [ROW_W-1:0]  ROW_LAST = '1;
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst) lfsr != 32'd0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !rst) |=> (req_valid && $stable(req_row) && $stable(req_bank)));

  assert_neighbour_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && (!req_valid || req_ready)) |=>
      (req_valid && req_bank == $past(evt_bank) &&
       (req_row == $past(evt_row) + 1'b1 || req_row == $past(evt_row) - 1'b1)));

  assert_low_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && (!req_valid || req_ready) && evt_row == '0) |=> (req_row == ROW_W'(1)));

  assert_high_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && (!req_valid || req_ready) && evt_row == ROW_LAST) |=> (req_row == ROW_LAST - 1'b1));

  assert_zero_threshold_R4: assert property (@(posedge clk) disable iff (rst)
    (thr_q == 16'd0 && (!req_valid || req_ready)) |=> !req_valid);

  assert_open_no_trial_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_close) |-> !hit);

  assert_drop_step_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && req_valid && !req_ready && drop_count != DROP_MAX) |=> (drop_count == $past(drop_count) + 1'b1));

  assert_drop_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_count >= $past(drop_count)));
endmodule

bind para_refresher para_refresher_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_close(evt_close),
  .evt_bank(evt_bank), .evt_row(evt_row), .req_ready(req_ready),
  .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
  .drop_count(drop_count), .thr_q(thr_q), .hit(hit), .lfsr(lfsr)
);

// File: tb/para_refresher_test.sv
`timescale 1ns/1ps
module para_refresher_test;
  localparam int ROW_W = 14, BANK_W = 3, DROP_W = 8;
  localparam logic [ROW_W-1:0] LAST = '1;
  localparam int STAT_N = 150000, STAT_THR = 328;

  logic clk = 0, rst = 1, cfg_we = 0, evt_valid = 0, evt_close = 0, req_ready = 0;
  logic [15:0] cfg_threshold = 0;
  logic [BANK_W-1:0] evt_bank = 0;
  logic [ROW_W-1:0]  evt_row = 0;
  logic req_valid;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [DROP_W-1:0] drop_count;

  always #10 clk = ~clk;

  para_refresher #(.ROW_W(ROW_W), .BANK_W(BANK_W), .DROP_W(DROP_W)) uut (.*);

  int compared = 0, mismatched = 0;
  bit done = 0, stat_on = 0;
  int seen_valid = 0, accepted = 0;

  // behavioural reference model
  longint unsigned m_lfsr;
  int m_thr, m_drop, m_bank, m_row;
  bit m_pend;
  int last_row, last_bank;

  function automatic longint unsigned next_rand(longint unsigned s);
    if (s % 2 == 1) return (s / 2) ^ 64'h80200003;
    return s / 2;
  endfunction

  always @(posedge clk) begin
    last_row  = evt_row;
    last_bank = evt_bank;
    if (rst) begin
      m_lfsr = 64'hC0FFEE11; m_thr = 0; m_pend = 0; m_drop = 0; m_bank = 0; m_row = 0;
    end else begin
      bit fire, free;
      fire = evt_valid && evt_close && int'(m_lfsr % 65536) < m_thr;  // R4 R3
      free = !m_pend || req_ready;                                    // R9
      if (fire && free) begin
        m_pend = 1; m_bank = evt_bank;
        if (evt_row == 0) m_row = 1;                                  // R7
        else if (evt_row == LAST) m_row = int'(LAST) - 1;
        else m_row = ((m_lfsr >> 31) % 2 == 1) ? int'(evt_row) + 1 : int'(evt_row) - 1; // R6
      end else if (req_ready) m_pend = 0;
      if (fire && !free && m_drop < 255) m_drop++;                   // R10
      if (cfg_we) m_thr = cfg_threshold;                              // R5
      m_lfsr = next_rand(m_lfsr);                                     // R2
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    check(req_valid == m_pend, "R2 R8 req_valid", req_valid, m_pend);
    if (m_pend) begin
      check(req_row == m_row, "R6 R7 req_row", req_row, m_row);
      check(req_bank == m_bank, "R6 req_bank", req_bank, m_bank);
    end
    check(drop_count == m_drop, "R10 drop_count", drop_count, m_drop);
    if (req_valid) seen_valid++;
    if (stat_on && req_valid && req_ready) begin
      int d;
      accepted++;
      d = int'(req_row) - last_row;
      check(d == 1 || d == -1, "R11 distance", d, 1);
      check(req_bank == last_bank, "R11 bank", req_bank, last_bank);
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic ev(input bit close, input int bank, input int row);
    evt_valid = 1; evt_close = close; evt_bank = bank[BANK_W-1:0]; evt_row = row[ROW_W-1:0];
    tick(); evt_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 0; tick();
    check(req_valid == 0, "R1 reset valid", req_valid, 0);
    check(drop_count == 0, "R1 reset drops", drop_count, 0);

    // zero threshold: closes never fire
    req_ready = 1; seen_valid = 0;
    for (int i = 0; i < 2000; i++) ev(1, i % 8, i);
    check(seen_valid == 0, "R4 zero threshold", seen_valid, 0);

    // threshold write takes effect one cycle later
    cfg_we = 1; cfg_threshold = 16'hFFFF; evt_valid = 1; evt_close = 1; evt_row = 100;
    tick(); cfg_we = 0; evt_valid = 0;
    check(req_valid == 0, "R5 write latency", req_valid, 0);
    tick();

    // open events only, maximal threshold
    seen_valid = 0;
    for (int i = 0; i < 500; i++) ev(0, i % 8, i + 7);
    tick();
    check(seen_valid == 0, "R3 opens ignored", seen_valid, 0);

    // edge rows
    ev(1, 5, 0);
    if (m_pend) check(req_row == 1, "R7 low edge", req_row, 1);
    ev(1, 2, int'(LAST));
    if (m_pend) check(req_row == LAST - 1, "R7 high edge", req_row, int'(LAST) - 1);
    tick();

    // back-pressure: held request, drops saturate
    req_ready = 0;
    ev(1, 3, 4000);
    begin
      int held;
      held = req_row;
      for (int i = 0; i < 300; i++) ev(1, i % 8, 50 + i);
      check(req_row == held, "R8 held row", req_row, held);
      check(req_valid == 1, "R8 held valid", req_valid, 1);
      check(drop_count == 255, "R10 saturation", drop_count, 255);
    end
    // mixed ready with same-cycle refill
    for (int i = 0; i < 400; i++) begin
      req_ready = (i % 3 != 0);
      ev(1, i % 8, (i * 37) % 16384);
    end
    req_ready = 1; tick();

    // reset again
    rst = 1; tick(); tick(); rst = 0; tick();
    check(drop_count == 0 && req_valid == 0, "R1 second reset", drop_count, 0);

    // statistical rate
    cfg_we = 1; cfg_threshold = STAT_THR[15:0]; tick(); cfg_we = 0;
    tick(); tick();
    stat_on = 1; accepted = 0;
    evt_valid = 1; evt_close = 1;
    for (int i = 0; i < STAT_N; i++) begin
      evt_bank = $urandom % 8;
      evt_row = (i % 1000 == 0) ? '0 : (i % 1000 == 1) ? LAST : ROW_W'($urandom);
      tick();
    end
    evt_valid = 0; tick();
    stat_on = 0;
    begin
      int expv;
      expv = int'((longint'(STAT_N) * STAT_THR) / 65536);
      check(accepted > expv * 8 / 10 && accepted < expv * 12 / 10, "R11 rate", accepted, expv);
    end
    finish_run();
  end
endmodule